// File: doc/BRIEF.md
# Programmable Local Bus Strobe Timer

This block produces the active-low chip-select strobes for a peripheral bus that sits behind a host bus bridge. A transaction is accepted with a start pulse that carries a read/write flag and a select index. The block then waits for the host master's IRDY# to be seen low. The reference cycle falls two clocks after that point. Counting from the reference cycle, the addressed chip select goes low and comes back high at clock offsets taken from a 16-bit timing word. Reads and writes each have their own pair of offsets.

The timing word holds four 4-bit offsets and is written through a plain register port. Its reset value depends on a parallel-port strap, which changes only the read de-assertion default. A one-clock done pulse closes each transaction, and the block is then ready for the next start.

Top module: `lbus_strobe_timer`

## Requirements
- R1: After reset the timing offsets are: read assert 0, write assert 0, write de-assert 3. Read de-assert is 3 when `pport_mode` is 0 during reset and 2 when it is 1.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the timing word. Bits 3:0 hold the read assert offset, 7:4 the read de-assert offset, 11:8 the write assert offset and 15:12 the write de-assert offset.
- R3: Let E be the first rising edge at which the block is waiting and sees `irdy_n` low. The reference edge is E+2. An offset N refers to the cycle that begins at edge E+2+N.
- R4: A start with `txn_write`=0 uses the read offsets. A start with `txn_write`=1 uses the write offsets.
- R5: Only `cs_n[txn_sel]` of the accepted transaction is ever driven low. Every other chip select stays high, and all chip selects are high while no transaction is in progress.
- R6: With assert offset A and de-assert offset D where D>A, the selected `cs_n` is low in exactly the cycles that begin at edges E+2+A through E+2+D-1.
- R7: When D<=A, the selected `cs_n` is low for exactly one cycle, the one that begins at edge E+2+A.
- R8: `done` is high for exactly one cycle, the first cycle after the low window (edge E+2+Deff, where Deff is D, or A+1 when D<=A). All chip selects are high in that cycle. The block is idle after the next edge.
- R9: A `txn_start` that arrives between acceptance and `done` is ignored. It produces no second strobe and no second `done`.
- R10: For any number of cycles before `irdy_n` goes low, the block waits with all chip selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pport_mode | input | 1 | Parallel-port strap; selects the read de-assert reset value |
| cfg_we | input | 1 | Timing word write enable |
| cfg_wdata | input | 16 | Timing word write data |
| txn_start | input | 1 | Transaction start pulse, accepted only when idle |
| txn_write | input | 1 | 1 = write, 0 = read, sampled with the start |
| txn_sel | input | 1 | Chip-select index, sampled with the start |
| irdy_n | input | 1 | Host master ready, active low |
| cs_n | output | 2 | Chip selects, active low |
| done | output | 1 | One-clock end-of-transaction pulse |

## Verification
The bench measures the exact cycle of each strobe edge relative to the edge where IRDY# is first seen low. A design that dropped or added a reference delay cycle, or that treated the de-assert offset as inclusive, shows up as a window shifted or one cycle too long. The folded cases, where de-assert is equal to or below assert and where assert is 15, catch a design that never strobes or that wraps its 4-bit counter and hangs. A start pulse injected mid-transaction while IRDY# is still low would launch a second strobe if the busy guard were missing. A reset with the parallel-port strap set must shorten the default read window by one clock.

// File: rtl/lbst_pkg.sv
package lbst_pkg;
  parameter int OFS_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REF,
    ST_RUN
  } lbst_state_e;

  typedef struct packed {
    logic [OFS_W-1:0] wr_deas;
    logic [OFS_W-1:0] wr_asrt;
    logic [OFS_W-1:0] rd_deas;
    logic [OFS_W-1:0] rd_asrt;
  } lbst_timing_t;
endpackage

// File: rtl/lbst_regs.sv
module lbst_regs
  import lbst_pkg::*;
#(
  parameter int W_DEAS_RST = 3,
  parameter int R_DEAS_RST = 3,
  parameter int R_DEAS_PP  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pport_mode,
  input  logic                 cfg_we,
  input  logic [4*OFS_W-1:0]   cfg_wdata,
  output lbst_timing_t         timing
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing.rd_asrt <= '0;
      timing.wr_asrt <= '0;
      timing.wr_deas <= OFS_W'(W_DEAS_RST);
      timing.rd_deas <= pport_mode ? OFS_W'(R_DEAS_PP) : OFS_W'(R_DEAS_RST);
    end else if (cfg_we) begin
      timing <= lbst_timing_t'(cfg_wdata);
    end
  end
endmodule

// File: rtl/lbst_seq.sv
module lbst_seq
  import lbst_pkg::*;
#(
  parameter int SEL_W   = 1,
  parameter int REF_DLY = 2,
  localparam int CNT_W  = OFS_W + 1,
  localparam int DLY_W  = (REF_DLY > 1) ? $clog2(REF_DLY) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_start,
  input  logic             txn_write,
  input  logic [SEL_W-1:0] txn_sel,
  input  logic             irdy_n,
  input  lbst_timing_t     timing,
  output logic             run,
  output logic [CNT_W-1:0] tcnt,
  output logic [CNT_W-1:0] asrt_ofs,
  output logic [CNT_W-1:0] deas_eff,
  output logic [SEL_W-1:0] sel_q,
  output logic             done
);
  lbst_state_e      state;
  logic             wr_q;
  logic [DLY_W-1:0] dcnt;
  logic [CNT_W-1:0] deas_raw;

  always_comb begin
    asrt_ofs = wr_q ? CNT_W'(timing.wr_asrt) : CNT_W'(timing.rd_asrt);
    deas_raw = wr_q ? CNT_W'(timing.wr_deas) : CNT_W'(timing.rd_deas);
    deas_eff = (deas_raw <= asrt_ofs) ? asrt_ofs + CNT_W'(1) : deas_raw;
    run      = (state == ST_RUN);
    done     = run && (tcnt == deas_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wr_q  <= 1'b0;
      sel_q <= '0;
      dcnt  <= '0;
      tcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (txn_start) begin
          wr_q  <= txn_write;
          sel_q <= txn_sel;
          state <= ST_WAIT;
        end
        ST_WAIT: if (!irdy_n) begin
          dcnt  <= DLY_W'(REF_DLY - 1);
          state <= ST_REF;
        end
        ST_REF: begin
          if (dcnt == '0) begin
            tcnt  <= '0;
            state <= ST_RUN;
          end else begin
            dcnt <= dcnt - DLY_W'(1);
          end
        end
        ST_RUN: begin
          if (done) state <= ST_IDLE;
          else      tcnt  <= tcnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbst_csgen.sv
module lbst_csgen #(
  parameter int NUM_CS = 2,
  parameter int SEL_W  = 1,
  parameter int CNT_W  = 5
) (
  input  logic              run,
  input  logic [CNT_W-1:0]  tcnt,
  input  logic [CNT_W-1:0]  asrt_ofs,
  input  logic [CNT_W-1:0]  deas_eff,
  input  logic [SEL_W-1:0]  sel_q,
  output logic [NUM_CS-1:0] cs_n
);
  logic in_win;

  assign in_win = run && (tcnt >= asrt_ofs) && (tcnt < deas_eff);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(in_win && (sel_q == SEL_W'(i)));
  end
endmodule

// File: rtl/lbus_strobe_timer.sv
module lbus_strobe_timer
  import lbst_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int REF_DLY  = 2,
  localparam int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CNT_W   = OFS_W + 1,
  localparam int WORD_W  = 4 * OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pport_mode,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              txn_start,
  input  logic              txn_write,
  input  logic [SEL_W-1:0]  txn_sel,
  input  logic              irdy_n,
  output logic [NUM_CS-1:0] cs_n,
  output logic              done
);
  lbst_timing_t     timing;
  logic             run;
  logic [CNT_W-1:0] tcnt, asrt_ofs, deas_eff;
  logic [SEL_W-1:0] sel_q;

  lbst_regs u_regs (
    .clk(clk), .rst_n(rst_n), .pport_mode(pport_mode),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .timing(timing)
  );

  lbst_seq #(.SEL_W(SEL_W), .REF_DLY(REF_DLY)) u_seq (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_write(txn_write),
    .txn_sel(txn_sel), .irdy_n(irdy_n), .timing(timing), .run(run),
    .tcnt(tcnt), .asrt_ofs(asrt_ofs), .deas_eff(deas_eff), .sel_q(sel_q),
    .done(done)
  );

  lbst_csgen #(.NUM_CS(NUM_CS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cs (
    .run(run), .tcnt(tcnt), .asrt_ofs(asrt_ofs), .deas_eff(deas_eff),
    .sel_q(sel_q), .cs_n(cs_n)
  );
endmodule

// File: rtl/lbst_checker.sv
module lbst_checker #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              done
);
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&cs_n)); // R8
  AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(~&cs_n)); // R6
endmodule

bind lbus_strobe_timer lbst_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .done(done)
);

// File: tb/lbus_strobe_timer_tb.sv
`timescale 1ns/1ps
module lbus_strobe_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pport_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        txn_start = 1'b0;
  logic        txn_write = 1'b0;
  logic [0:0]  txn_sel = '0;
  logic        irdy_n = 1'b1;
  logic [1:0]  cs_n;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lbus_strobe_timer dut_i (
    .clk(clk), .rst_n(rst_n), .pport_mode(pport_mode), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .txn_start(txn_start), .txn_write(txn_write),
    .txn_sel(txn_sel), .irdy_n(irdy_n), .cs_n(cs_n), .done(done)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit pp);
    @(negedge clk);
    pport_mode = pp;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "cs_n after reset", int'(cs_n), 3);
    chk("R8", "done after reset", int'(done), 0);
  endtask

  task automatic write_cfg(logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One transaction: ea = assert offset, ed = effective de-assert offset.
  task automatic run_txn(string req, bit wr, int sel, int lag, int ea, int ed, bit poke);
    int cs_err = 0, cs_act = 0, cs_exp = 0, cs_at = -1;
    int dn_err = 0, dn_act = 0, dn_exp = 0, wait_err = 0;
    @(negedge clk);
    txn_start = 1'b1; txn_write = wr; txn_sel = 1'(sel);
    @(negedge clk);
    txn_start = 1'b0;
    for (int k = 0; k < lag; k++) begin
      @(negedge clk);
      if (cs_n != 2'b11 || done) wait_err++;
    end
    irdy_n = 1'b0;
    for (int c = 0; c < 26; c++) begin
      logic [1:0] exp_cs;
      logic       exp_dn;
      @(negedge clk);
      if (poke && c == 3) begin
        txn_start = 1'b1; txn_write = ~wr; txn_sel = 1'(1 - sel);
      end
      if (poke && c == 4) txn_start = 1'b0;
      exp_cs = 2'b11;
      if (c >= 2 + ea && c < 2 + ed) exp_cs[sel] = 1'b0;
      exp_dn = (c == 2 + ed);
      if (cs_n !== exp_cs && cs_err == 0) begin
        cs_act = int'(cs_n); cs_exp = int'(exp_cs); cs_at = c;
      end
      if (cs_n !== exp_cs) cs_err++;
      if (done !== exp_dn && dn_err == 0) begin
        dn_act = int'(done); dn_exp = int'(exp_dn);
      end
      if (done !== exp_dn) dn_err++;
    end
    irdy_n = 1'b1;
    chk("R10", {req, " cs high while waiting for irdy"}, wait_err, 0);
    if (cs_err != 0) $display("  (cs mismatch first at cycle %0d: %0d vs %0d)", cs_at, cs_act, cs_exp);
    chk(req, "cs_n window mismatching cycles", cs_err, 0);
    if (dn_err != 0) $display("  (done first mismatch: %0d vs %0d)", dn_act, dn_exp);
    chk("R8", {req, " done pulse mismatching cycles"}, dn_err, 0);
  endtask

  task automatic t_defaults();
    do_reset(1'b0);
    run_txn("R1 R3 R6 read defaults", 1'b0, 0, 0, 0, 3, 1'b0);
    run_txn("R1 R4 R5 write defaults sel1", 1'b1, 1, 0, 0, 3, 1'b0);
  endtask

  task automatic t_programmed();
    write_cfg(16'h9251);
    run_txn("R2 R4 read programmed sel1", 1'b0, 1, 3, 1, 5, 1'b0);
    run_txn("R2 R4 write programmed sel0", 1'b1, 0, 5, 2, 9, 1'b0);
  endtask

  task automatic t_folded();
    write_cfg(16'h3744);
    run_txn("R7 read deassert equal", 1'b0, 0, 1, 4, 5, 1'b0);
    run_txn("R7 write deassert below", 1'b1, 1, 0, 7, 8, 1'b0);
    write_cfg(16'h0F00);
    run_txn("R7 write assert max", 1'b1, 0, 0, 15, 16, 1'b0);
    run_txn("R7 read zero zero", 1'b0, 1, 2, 0, 1, 1'b0);
  endtask

  task automatic t_busy();
    do_reset(1'b0);
    run_txn("R9 start ignored while busy", 1'b0, 0, 2, 0, 3, 1'b1);
  endtask

  task automatic t_pport();
    do_reset(1'b1);
    run_txn("R1 pport read default", 1'b0, 0, 0, 0, 2, 1'b0);
    run_txn("R1 pport write default", 1'b1, 1, 0, 0, 3, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_defaults();
        t_programmed();
        t_folded();
        t_busy();
        t_pport();
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule